// File: doc/BRIEF.md
# Parallel-Correlator Code Acquisition Front End

This block is the time-domain half of an acquisition engine for a direct-sequence signal whose spreading code is `CODE_LEN` chips long. Samples arrive at two per chip, so one half-chip step is one sample. A bank of `NUM_CORR` correlators tests `NUM_CORR` neighbouring code offsets at once. Correlator k multiplies each sample by the local replica delayed by k samples. It sums the products over a segment of programmable chip length and stores each segment's complex partial sum in its own buffer. A pass integrates over `NUM_PER` code periods. The segment length can be chosen freely, so the data symbol rate never has to line up with the code period.

At the end of a pass the buffers are streamed correlator by correlator to an external FFT over a valid/ready interface. The FFT returns one peak, one noise figure and one Doppler bin per correlator. The block declares a detection when the peak exceeds the noise scaled by a threshold. It then latches the half-chip code offset and the Doppler bin and stops searching at once. If no detection occurs, it asks the external code generator to advance by `NUM_CORR` half-chips and runs the next pass. Once every offset from 0 to 2·`CODE_LEN`−1 has been tried without a hit, it raises a fail flag.

Top module: `acq_front`

## Requirements
- R1: While reset is low and after its release, `busy_o`, `found_o`, `fail_o`, `fft_valid_o` and `pass_run_o` are all low.
- R2: A start pulse while idle begins pass 0 on the next cycle, with `pass_run_o` high and `code_phase_o` = 0. A start pulse while busy is ignored: the pass and the stream in progress continue unchanged.
- R3: Correlator k multiplies each accepted sample by the replica delayed by k accepted samples. A replica bit of 1 weighs the sample +1 and a bit of 0 weighs it −1. Delay taps that are still empty since the pass began contribute zero. Cycles with `samp_vld_i` low are skipped entirely.
- R4: A segment is 2·L accepted samples, where L = max(`seg_len_i`, `SEG_MIN`) is sampled at start. A pass accepts `NUM_PER`·`CODE_LEN`·2 samples. Complete segments are stored in order at buffer index 0, 1, 2, … up to `BUF_DEPTH` entries. A trailing incomplete segment is discarded.
- R5: After integration, correlators are streamed in increasing k, `FFT_LEN` words each. Word j carries stored partial j as real and imaginary parts, or zero when j is not below the number of stored partials. `fft_last_o` marks word `FFT_LEN`−1.
- R6: While `fft_valid_o` is high and `fft_ready_i` is low, the word, its parts and `fft_last_o` hold steady.
- R7: After each correlator's stream, the block waits for one `res_valid_i` pulse. A detection requires `res_peak_i` > `res_noise_i`·`thr_i`; equality is not a detection.
- R8: On a detection, `found_o` rises, `code_off_o` = pass·`NUM_CORR` + k and `dop_bin_o` = `res_bin_i`. No further correlator is streamed.
- R9: During pass p, `code_phase_o` = p·`NUM_CORR`. There are ceil(2·`CODE_LEN`/`NUM_CORR`) passes.
- R10: Correlators whose offset exceeds 2·`CODE_LEN`−1 are never streamed, so a search without a hit streams exactly 2·`CODE_LEN` blocks.
- R11: If the last block of the last pass gives no detection, `fail_o` rises and `busy_o` falls. `found_o` and `fail_o` are never high together.
- R12: `found_o`, `fail_o`, `code_off_o` and `dop_bin_o` hold until the next accepted start, which clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (accepted while idle) |
| seg_len_i | input | SLW | Segment length in chips |
| thr_i | input | TW | Detection threshold (peak/noise ratio) |
| samp_vld_i | input | 1 | Sample strobe, one per half-chip |
| samp_re_i | input | SW | Sample real part, signed |
| samp_im_i | input | SW | Sample imaginary part, signed |
| code_i | input | 1 | Replica chip from external generator at `code_phase_o` |
| pass_run_o | output | 1 | Integration window of the current pass is open |
| code_phase_o | output | OFFW | Half-chip offset of correlator 0 this pass |
| fft_valid_o | output | 1 | Stream word valid |
| fft_ready_i | input | 1 | FFT accepts the word |
| fft_re_o | output | AW | Stream word real part, signed |
| fft_im_o | output | AW | Stream word imaginary part, signed |
| fft_last_o | output | 1 | Final word of one correlator's block |
| res_valid_i | input | 1 | FFT result strobe |
| res_peak_i | input | PW | Peak magnitude of the block |
| res_noise_i | input | PW | Noise estimate of the block |
| res_bin_i | input | BINW | Doppler bin of the peak |
| busy_o | output | 1 | Search in progress |
| found_o | output | 1 | Detection latched |
| fail_o | output | 1 | All offsets tried without detection |
| code_off_o | output | OFFW | Latched winning half-chip offset |
| dop_bin_o | output | BINW | Latched winning Doppler bin |

## Verification
The assertions assume that `res_valid_i` pulses only while a result is awaited, so that a rise of `found_o` can be traced to a result strobe. They also assume that `fft_ready_i` may toggle freely without disturbing a pending word. The stimulus follows these assumptions: a result is driven only in the cycle after a block's last word has been accepted, and ready is held high or toggled every cycle. Samples and the replica bit are held constant during a run. This lets the partial sums be derived from the segment length, the correlator's delay and the number of stored segments alone, regardless of gaps in the sample strobe.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_INTEG  = 2'd1,
    S_STREAM = 2'd2,
    S_WAIT   = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_corr_bank.sv
module acq_corr_bank #(
  parameter int NC        = 64,
  parameter int BUF_DEPTH = 16,
  parameter int SW        = 8,
  parameter int AW        = 18,
  localparam int BIW      = $clog2(BUF_DEPTH),
  localparam int CW       = $clog2(NC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 seg_end_i,
  input  logic                 wr_ok_i,
  input  logic [BIW-1:0]       wr_idx_i,
  input  logic signed [SW-1:0] samp_re_i,
  input  logic signed [SW-1:0] samp_im_i,
  input  logic                 code_i,
  input  logic [CW-1:0]        rd_corr_i,
  input  logic [BIW-1:0]       rd_idx_i,
  output logic signed [AW-1:0] rd_re_o,
  output logic signed [AW-1:0] rd_im_o
);
  // replica delay line: entry i holds the chip delayed by i+1 samples
  logic [NC-2:0] code_sh, vld_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_sh <= '0;
      vld_sh  <= '0;
    end else if (clr_i) begin
      vld_sh  <= '0;
    end else if (en_i) begin
      code_sh[0] <= code_i;
      vld_sh[0]  <= 1'b1;
      for (int i = 1; i < NC-1; i++) begin
        code_sh[i] <= code_sh[i-1];
        vld_sh[i]  <= vld_sh[i-1];
      end
    end
  end

  logic signed [AW-1:0] s_re, s_im;
  assign s_re = AW'(samp_re_i);
  assign s_im = AW'(samp_im_i);

  logic signed [AW-1:0] rd_re [NC];
  logic signed [AW-1:0] rd_im [NC];

  for (genvar k = 0; k < NC; k++) begin : g_corr
    logic tap_c, tap_v;
    if (k == 0) begin : g_tap0
      assign tap_c = code_i;
      assign tap_v = 1'b1;
    end else begin : g_tapn
      assign tap_c = code_sh[k-1];
      assign tap_v = vld_sh[k-1];
    end

    logic signed [AW-1:0] p_re, p_im, acc_re, acc_im, n_re, n_im;
    assign p_re = !tap_v ? '0 : (tap_c ? s_re : -s_re);
    assign p_im = !tap_v ? '0 : (tap_c ? s_im : -s_im);
    assign n_re = acc_re + p_re;
    assign n_im = acc_im + p_im;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_re <= '0;
        acc_im <= '0;
      end else if (clr_i) begin
        acc_re <= '0;
        acc_im <= '0;
      end else if (en_i) begin
        acc_re <= seg_end_i ? '0 : n_re;
        acc_im <= seg_end_i ? '0 : n_im;
      end
    end

    logic signed [AW-1:0] mem_re [BUF_DEPTH];
    logic signed [AW-1:0] mem_im [BUF_DEPTH];

    always_ff @(posedge clk_i) begin
      if (en_i && seg_end_i && wr_ok_i) begin
        mem_re[wr_idx_i] <= n_re;
        mem_im[wr_idx_i] <= n_im;
      end
    end

    assign rd_re[k] = mem_re[rd_idx_i];
    assign rd_im[k] = mem_im[rd_idx_i];
  end

  assign rd_re_o = rd_re[rd_corr_i];
  assign rd_im_o = rd_im[rd_corr_i];
endmodule

// File: rtl/acq_detect.sv
module acq_detect #(
  parameter int PW = 24,
  parameter int TW = 8
) (
  input  logic [PW-1:0] peak_i,
  input  logic [PW-1:0] noise_i,
  input  logic [TW-1:0] thr_i,
  output logic          hit_o
);
  logic [PW+TW-1:0] bar;
  assign bar   = (PW+TW)'(noise_i) * (PW+TW)'(thr_i);
  assign hit_o = (PW+TW)'(peak_i) > bar;
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int CODE_LEN  = 1023,
  parameter int NC        = 64,
  parameter int NUM_PER   = 4,
  parameter int SEG_MIN   = 16,
  parameter int BUF_DEPTH = 16,
  parameter int FFT_LEN   = 16,
  parameter int SLW       = 8,
  parameter int OFFW      = 11,
  parameter int BINW      = 4,
  localparam int BIW      = $clog2(BUF_DEPTH),
  localparam int BAW      = $clog2(BUF_DEPTH + 1),
  localparam int CW       = $clog2(NC),
  localparam int WW       = $clog2(FFT_LEN),
  localparam int PASS_S   = NUM_PER * CODE_LEN * 2,
  localparam int SCW      = $clog2(PASS_S),
  localparam int NUM_PASS = (2*CODE_LEN + NC - 1) / NC,
  localparam int LAST_CP  = (NUM_PASS - 1) * NC,
  localparam int MAX_OFF  = 2*CODE_LEN - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [SLW-1:0]  seg_len_i,
  input  logic            samp_vld_i,
  input  logic            fft_ready_i,
  input  logic            res_valid_i,
  input  logic            hit_i,
  input  logic [BINW-1:0] res_bin_i,
  output logic            clr_o,
  output logic            en_o,
  output logic            seg_end_o,
  output logic            wr_ok_o,
  output logic [BIW-1:0]  wr_idx_o,
  output logic [CW-1:0]   rd_corr_o,
  output logic [BIW-1:0]  rd_idx_o,
  output logic            zero_o,
  output logic            fft_valid_o,
  output logic            fft_last_o,
  output logic            pass_run_o,
  output logic [OFFW-1:0] code_phase_o,
  output logic            busy_o,
  output logic            found_o,
  output logic            fail_o,
  output logic [OFFW-1:0] code_off_o,
  output logic [BINW-1:0] dop_bin_o
);
  acq_state_e st;
  logic [SCW-1:0]  samp_cnt;
  logic [SLW:0]    seg_cnt, seg_top;
  logic [BAW-1:0]  stored;
  logic [CW-1:0]   corr;
  logic [WW-1:0]   word;
  logic [OFFW-1:0] cp;
  logic [SLW-1:0]  len_eff;
  logic [OFFW:0]   nxt_off;
  logic            end_pass, last_pass, last_samp, go, adv, miss;

  assign len_eff   = (seg_len_i < SLW'(SEG_MIN)) ? SLW'(SEG_MIN) : seg_len_i;
  assign en_o      = (st == S_INTEG) && samp_vld_i;
  assign seg_end_o = seg_cnt == seg_top;
  assign wr_ok_o   = stored < BAW'(BUF_DEPTH);
  assign wr_idx_o  = stored[BIW-1:0];
  assign last_samp = samp_cnt == SCW'(PASS_S - 1);
  assign nxt_off   = {1'b0, cp} + (OFFW+1)'(corr) + (OFFW+1)'(1);
  assign end_pass  = (corr == CW'(NC - 1)) || (nxt_off > (OFFW+1)'(MAX_OFF));
  assign last_pass = cp == OFFW'(LAST_CP);
  assign go        = (st == S_IDLE) && start_i;
  assign miss      = (st == S_WAIT) && res_valid_i && !hit_i;
  assign adv       = miss && end_pass && !last_pass;
  assign clr_o     = go || adv;

  assign rd_corr_o    = corr;
  assign rd_idx_o     = BIW'(word);
  assign zero_o       = BAW'(word) >= stored;
  assign fft_valid_o  = st == S_STREAM;
  assign fft_last_o   = (st == S_STREAM) && (word == WW'(FFT_LEN - 1));
  assign pass_run_o   = st == S_INTEG;
  assign code_phase_o = cp;
  assign busy_o       = st != S_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= S_IDLE;
      samp_cnt   <= '0;
      seg_cnt    <= '0;
      seg_top    <= '0;
      stored     <= '0;
      corr       <= '0;
      word       <= '0;
      cp         <= '0;
      found_o    <= 1'b0;
      fail_o     <= 1'b0;
      code_off_o <= '0;
      dop_bin_o  <= '0;
    end else begin
      if (clr_o) begin
        samp_cnt <= '0;
        seg_cnt  <= '0;
        stored   <= '0;
      end
      unique case (st)
        S_IDLE: if (start_i) begin
          st      <= S_INTEG;
          found_o <= 1'b0;
          fail_o  <= 1'b0;
          cp      <= '0;
          seg_top <= {len_eff, 1'b0} - (SLW+1)'(1);
        end
        S_INTEG: if (en_o) begin
          samp_cnt <= samp_cnt + SCW'(1);
          seg_cnt  <= seg_end_o ? '0 : seg_cnt + (SLW+1)'(1);
          if (seg_end_o && wr_ok_o) stored <= stored + BAW'(1);
          if (last_samp) begin
            st   <= S_STREAM;
            corr <= '0;
            word <= '0;
          end
        end
        S_STREAM: if (fft_ready_i) begin
          if (word == WW'(FFT_LEN - 1)) begin
            st   <= S_WAIT;
            word <= '0;
          end else begin
            word <= word + WW'(1);
          end
        end
        S_WAIT: if (res_valid_i) begin
          if (hit_i) begin
            st         <= S_IDLE;
            found_o    <= 1'b1;
            code_off_o <= cp + OFFW'(corr);
            dop_bin_o  <= res_bin_i;
          end else if (!end_pass) begin
            st   <= S_STREAM;
            corr <= corr + CW'(1);
          end else if (!last_pass) begin
            st <= S_INTEG;
            cp <= cp + OFFW'(NC);
          end else begin
            st     <= S_IDLE;
            fail_o <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acq_front.sv
module acq_front #(
  parameter int CODE_LEN  = 1023,
  parameter int NUM_CORR  = 64,
  parameter int NUM_PER   = 4,
  parameter int SEG_MIN   = 16,
  parameter int BUF_DEPTH = 16,
  parameter int FFT_LEN   = 16,
  parameter int SW        = 8,
  parameter int SLW       = 8,
  parameter int PW        = 24,
  parameter int TW        = 8,
  localparam int AW       = SW + SLW + 2,
  localparam int NUM_PASS = (2*CODE_LEN + NUM_CORR - 1) / NUM_CORR,
  localparam int OFFW     = $clog2(NUM_PASS * NUM_CORR),
  localparam int BINW     = $clog2(FFT_LEN),
  localparam int MAX_OFF  = 2*CODE_LEN - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [SLW-1:0]       seg_len_i,
  input  logic [TW-1:0]        thr_i,
  input  logic                 samp_vld_i,
  input  logic signed [SW-1:0] samp_re_i,
  input  logic signed [SW-1:0] samp_im_i,
  input  logic                 code_i,
  output logic                 pass_run_o,
  output logic [OFFW-1:0]      code_phase_o,
  output logic                 fft_valid_o,
  input  logic                 fft_ready_i,
  output logic signed [AW-1:0] fft_re_o,
  output logic signed [AW-1:0] fft_im_o,
  output logic                 fft_last_o,
  input  logic                 res_valid_i,
  input  logic [PW-1:0]        res_peak_i,
  input  logic [PW-1:0]        res_noise_i,
  input  logic [BINW-1:0]      res_bin_i,
  output logic                 busy_o,
  output logic                 found_o,
  output logic                 fail_o,
  output logic [OFFW-1:0]      code_off_o,
  output logic [BINW-1:0]      dop_bin_o
);
  localparam int BIW = $clog2(BUF_DEPTH);
  localparam int CW  = $clog2(NUM_CORR);

  logic clr, en, seg_end, wr_ok, zero, hit;
  logic [BIW-1:0] wr_idx, rd_idx;
  logic [CW-1:0]  rd_corr;
  logic signed [AW-1:0] rd_re, rd_im;

  acq_detect #(.PW(PW), .TW(TW)) u_det (
    .peak_i (res_peak_i),
    .noise_i(res_noise_i),
    .thr_i  (thr_i),
    .hit_o  (hit)
  );

  acq_ctrl #(
    .CODE_LEN(CODE_LEN), .NC(NUM_CORR), .NUM_PER(NUM_PER), .SEG_MIN(SEG_MIN),
    .BUF_DEPTH(BUF_DEPTH), .FFT_LEN(FFT_LEN), .SLW(SLW), .OFFW(OFFW), .BINW(BINW)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .seg_len_i, .samp_vld_i, .fft_ready_i, .res_valid_i,
    .hit_i       (hit),
    .res_bin_i,
    .clr_o       (clr),
    .en_o        (en),
    .seg_end_o   (seg_end),
    .wr_ok_o     (wr_ok),
    .wr_idx_o    (wr_idx),
    .rd_corr_o   (rd_corr),
    .rd_idx_o    (rd_idx),
    .zero_o      (zero),
    .fft_valid_o, .fft_last_o, .pass_run_o, .code_phase_o,
    .busy_o, .found_o, .fail_o, .code_off_o, .dop_bin_o
  );

  acq_corr_bank #(.NC(NUM_CORR), .BUF_DEPTH(BUF_DEPTH), .SW(SW), .AW(AW)) u_bank (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .en_i      (en),
    .seg_end_i (seg_end),
    .wr_ok_i   (wr_ok),
    .wr_idx_i  (wr_idx),
    .samp_re_i, .samp_im_i, .code_i,
    .rd_corr_i (rd_corr),
    .rd_idx_i  (rd_idx),
    .rd_re_o   (rd_re),
    .rd_im_o   (rd_im)
  );

  // words past the stored count are zero-filled
  assign fft_re_o = zero ? '0 : rd_re;
  assign fft_im_o = zero ? '0 : rd_im;
endmodule

// File: rtl/acq_front_chk.sv
module acq_front_chk #(
  parameter int OFFW    = 11,
  parameter int AW      = 18,
  parameter int MAX_OFF = 2045
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            fft_valid_o,
  input logic            fft_ready_i,
  input logic [AW-1:0]   fft_re_o,
  input logic [AW-1:0]   fft_im_o,
  input logic            fft_last_o,
  input logic            pass_run_o,
  input logic [OFFW-1:0] code_phase_o,
  input logic            res_valid_i,
  input logic            busy_o,
  input logic            found_o,
  input logic            fail_o,
  input logic [OFFW-1:0] code_off_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !fft_valid_o && !pass_run_o);

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fft_valid_o && !fft_ready_i |=> fft_valid_o && $stable(fft_re_o) && $stable(fft_im_o)
                                    && $stable(fft_last_o));

  p_no_stream_in_integ_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fft_valid_o |-> !pass_run_o);

  p_found_from_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_o) |-> $past(res_valid_i));

  p_phase_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_run_o && $past(pass_run_o) |-> $stable(code_phase_o));

  p_offset_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> code_off_o <= OFFW'(MAX_OFF));

  p_flags_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && fail_o));

  p_found_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o && !start_i |=> found_o && $stable(code_off_o));
endmodule

bind acq_front acq_front_chk #(.OFFW(OFFW), .AW(AW), .MAX_OFF(MAX_OFF)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fft_valid_o(fft_valid_o),
  .fft_ready_i(fft_ready_i), .fft_re_o(fft_re_o), .fft_im_o(fft_im_o),
  .fft_last_o(fft_last_o), .pass_run_o(pass_run_o), .code_phase_o(code_phase_o),
  .res_valid_i(res_valid_i), .busy_o(busy_o), .found_o(found_o), .fail_o(fail_o),
  .code_off_o(code_off_o)
);

// File: tb/tb_acq_front.sv
module tb_acq_front;
  localparam int CL = 31, NC = 8, NP = 4, SMIN = 4, BD = 16, FL = 8;
  localparam int SW = 8, SLW = 6, PW = 16, TW = 8;
  localparam int AW = SW + SLW + 2;
  localparam int NPASS = (2*CL + NC - 1) / NC;
  localparam int OFFW = $clog2(NPASS * NC);
  localparam int BINW = $clog2(FL);
  localparam int PASS_S = NP * CL * 2;
  localparam int THR = 3, NOISE = 10;
  localparam int NV = 5;
  // seg, re, im, code bit, strobe gaps, ready stalls, hit pass, hit corr, peak, bin, busy-start poke
  localparam int VEC [NV][11] = '{
    '{ 4,    3,   -2, 1, 0, 0, 2, 5,  31, 3, 0},
    '{ 1,   -5,    7, 0, 1, 1, 7, 5,  40, 6, 0},
    '{20,  127, -128, 1, 0, 0, 3, 0,  30, 1, 1},
    '{ 6,    1,    1, 0, 0, 1, 0, 0, 100, 7, 0},
    '{ 4, -128,  127, 0, 1, 0, 0, 0,   0, 2, 0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic start_i = 0, samp_vld_i = 0, code_i = 0, fft_ready_i = 0, res_valid_i = 0;
  logic [SLW-1:0] seg_len_i = '0;
  logic [TW-1:0] thr_i = TW'(THR);
  logic signed [SW-1:0] samp_re_i = '0, samp_im_i = '0;
  logic [PW-1:0] res_peak_i = '0, res_noise_i = '0;
  logic [BINW-1:0] res_bin_i = '0;
  logic pass_run_o, fft_valid_o, fft_last_o, busy_o, found_o, fail_o;
  logic [OFFW-1:0] code_phase_o, code_off_o;
  logic signed [AW-1:0] fft_re_o, fft_im_o;
  logic [BINW-1:0] dop_bin_o;
  bit gap_mode = 0;

  int n_chk = 0, n_fail = 0;

  acq_front #(.CODE_LEN(CL), .NUM_CORR(NC), .NUM_PER(NP), .SEG_MIN(SMIN), .BUF_DEPTH(BD),
              .FFT_LEN(FL), .SW(SW), .SLW(SLW), .PW(PW), .TW(TW)) dut (
    .clk_i(clk), .rst_ni, .start_i, .seg_len_i, .thr_i, .samp_vld_i, .samp_re_i, .samp_im_i,
    .code_i, .pass_run_o, .code_phase_o, .fft_valid_o, .fft_ready_i, .fft_re_o, .fft_im_o,
    .fft_last_o, .res_valid_i, .res_peak_i, .res_noise_i, .res_bin_i, .busy_o, .found_o,
    .fail_o, .code_off_o, .dop_bin_o
  );

  initial forever begin
    @(negedge clk);
    samp_vld_i = gap_mode ? ~samp_vld_i : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_part(int k, int j, int n, int stored, int s, int cb);
    int cnt;
    if (j >= stored) return 0;
    cnt = (j == 0) ? ((n > k) ? n - k : 0) : n;
    return (cb != 0 ? 1 : -1) * s * cnt;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run_vec(input int v);
    int seg = VEC[v][0], si = VEC[v][1], sq = VEC[v][2], cb = VEC[v][3];
    int stall = VEC[v][5], dp = VEC[v][6], dk = VEC[v][7], pk = VEC[v][8], bin = VEC[v][9];
    int L = (seg < SMIN) ? SMIN : seg;
    int n = 2 * L;
    int nseg = PASS_S / n;
    int stored = (nseg < BD) ? nseg : BD;
    bit want = pk > NOISE * THR;
    int blk = 0, word = 0, tmo = 0, bad_act = 0, bad_exp = 0, p, k, er, ei;
    bit done = 0, res_pend = 0, blk_ok = 1, ph_done = 0, tog = 0, poked = 0, poke_chk = 0;
    logic [OFFW-1:0] off_hold;

    seg_len_i = SLW'(seg); samp_re_i = SW'(si); samp_im_i = SW'(sq); code_i = cb[0];
    gap_mode = VEC[v][4] != 0; res_bin_i = BINW'(bin);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    chk(!found_o && !fail_o, "R12", "flags cleared by start", {found_o, fail_o}, 0);
    chk(pass_run_o && busy_o && code_phase_o == 0, "R2", "pass 0 begins",
        code_phase_o, 0);
    while (!done) begin
      @(negedge clk);
      tmo++;
      res_valid_i = 0;
      fft_ready_i = 0;
      if (poke_chk) begin
        start_i = 0;
        poke_chk = 0;
        chk(busy_o && fft_valid_o && code_phase_o == OFFW'(NC), "R2", "start while busy ignored",
            code_phase_o, NC);
      end
      if (tmo > 30000) begin
        chk(0, "R11", "run did not finish", tmo, 30000);
        done = 1;
      end else if (res_pend) begin
        p = blk / NC; k = blk % NC;
        res_peak_i  = PW'((p == dp && k == dk) ? pk : NOISE);
        res_noise_i = PW'(NOISE);
        res_valid_i = 1;
        res_pend = 0;
        blk++;
      end else if (fft_valid_o) begin
        p = blk / NC; k = blk % NC;
        if (!ph_done) begin
          chk(code_phase_o == OFFW'(p * NC), "R9", "code phase of pass", code_phase_o, p * NC);
          ph_done = 1;
        end
        er = exp_part(k, word, n, stored, si, cb);
        ei = exp_part(k, word, n, stored, sq, cb);
        if ((int'(fft_re_o) != er || int'(fft_im_o) != ei || fft_last_o != (word == FL-1))
            && blk_ok) begin
          blk_ok = 0; bad_act = int'(fft_re_o); bad_exp = er;
        end
        if (VEC[v][10] != 0 && p == 1 && word == 0 && !poked) begin
          start_i = 1; poked = 1; poke_chk = 1;
        end else begin
          tog = ~tog;
          fft_ready_i = (stall != 0) ? tog : 1'b1;
          if (fft_ready_i) begin
            if (word == FL - 1) begin
              chk(blk_ok, "R3 R4 R5 R6", $sformatf("block pass %0d corr %0d words", p, k),
                  bad_act, bad_exp);
              blk_ok = 1; ph_done = 0; word = 0; res_pend = 1;
            end else word++;
          end
        end
      end else if (!busy_o) done = 1;
    end
    chk(found_o == want, "R7 R8", "found flag", found_o, want);
    chk(fail_o == !want, "R11", "fail flag", fail_o, !want);
    if (want) begin
      chk(code_off_o == OFFW'(dp * NC + dk), "R8", "code offset", code_off_o, dp * NC + dk);
      chk(dop_bin_o == BINW'(bin), "R8", "doppler bin", dop_bin_o, bin);
      chk(blk == dp * NC + dk + 1, "R8", "blocks before stop", blk, dp * NC + dk + 1);
    end else begin
      chk(blk == 2 * CL, "R10", "blocks over whole search", blk, 2 * CL);
    end
    off_hold = code_off_o;
    repeat (5) @(negedge clk);
    chk(found_o == want && fail_o == !want && code_off_o == off_hold && !busy_o, "R12",
        "result held while idle", code_off_o, off_hold);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !found_o && !fail_o && !fft_valid_o && !pass_run_o, "R1",
        "outputs in reset", {busy_o, found_o, fail_o, fft_valid_o, pass_run_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !found_o && !fail_o && !fft_valid_o && !pass_run_o, "R1",
        "outputs after reset", {busy_o, found_o, fail_o, fft_valid_o, pass_run_o}, 0);
    for (int v = 0; v < NV; v++) run_vec(v);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=150000 expected=0");
    summary();
    $finish;
  end
endmodule